// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Initializer

This block sits on the controller side of an asynchronous DRAM. It runs on the system clock and keeps the array refreshed. Leaving reset, it holds all strobes inactive for a power-up delay. It then runs a short burst of CAS-before-RAS refresh cycles on its own. Only after that burst does it report that normal traffic may start.

From then on an interval timer produces one refresh obligation per row slot of the retention period. Obligations that cannot be served yet are counted, up to a fixed limit. The block asks the access sequencer for the bus through a request/grant pair. Once granted, it runs all counted refreshes back to back and then releases the bus. Every duration is given in nanoseconds or microseconds and is converted to clock cycles from the clock frequency parameter. Write enable is held inactive throughout, so a refresh cycle is never taken as a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset deasserts, RAS and CAS stay high for exactly POWERUP_US*CLK_MHZ clock cycles. The first CAS fall comes on the clock edge that ends that count.
- R2: After the power-up wait, the block runs INIT_CYCLES (default 8) refresh cycles without a grant. `init_done` rises on the edge after the last of these cycles' done pulse. `refresh_req` stays low while `init_done` is low.
- R3: Once `init_done` is high, one refresh obligation arises every RETENTION_US*CLK_MHZ/ROWS cycles (floor). RETENTION_US defaults to 32000, or 128000 when LOW_POWER is set. With nothing pending and grant low, `refresh_req` rises exactly one interval after `init_done` rises.
- R4: In every refresh cycle, CAS goes low at least 10 ns of cycles before RAS falls. CAS stays low for the whole RAS-low time and rises together with RAS.
- R5: `we_n` is high whenever RAS falls.
- R6: RAS low lasts at least 50, 60 or 70 ns for SPEED_GRADE 0, 1 or 2. RAS high between cycles lasts at least 30, 40 or 50 ns for those grades.
- R7: Before each CAS fall, CAS has been high for at least 5 ns of cycles.
- R8: After initialization, a refresh cycle starts only from an edge where grant is high, or directly after the done pulse of the previous cycle in the same burst. While grant stays low, the strobes stay high.
- R9: Up to MAX_PENDING (default 8) obligations are counted and further ones are dropped. After a grant, all counted obligations are served back to back. If an obligation arrives on the same edge that a cycle starts, it is added to the same burst.
- R10: `refresh_done` is a one-cycle pulse in the last precharge cycle of each refresh cycle, RP cycles after RAS rises. `refresh_req` falls on the edge after the final done pulse of a burst.
- R11: When no saturation occurs, the number of completed refresh cycles equals the number of obligations whenever `refresh_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Bus granted to the refresh block by the access sequencer |
| refresh_req | output | 1 | Refresh wants the bus; held until the burst finishes |
| refresh_done | output | 1 | One-cycle pulse at the end of each refresh cycle |
| init_done | output | 1 | Power-up wait and initial refresh burst complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The interval timer can add an obligation on the same edge that the sequencer starts a cycle and takes one away. This can leave the counter wrong by one, or drop the new obligation. The bench provokes this overlap on purpose: it lets two obligations build up and then raises grant in the cycle just before the next interval expires. It then expects exactly three done pulses before the request falls. The random grant phase also checks that completed cycles always balance the obligations each time the request drops.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_PRE
  } ref_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ras_low_ns(input int grade);
    return 50 + 10 * grade;
  endfunction

  function automatic int precharge_ns(input int grade);
    return 30 + 10 * grade;
  endfunction

  // cycles between refresh obligations, rounded down so refresh is early
  function automatic int refresh_interval(input int ret_us, input int mhz, input int rows);
    return (ret_us * mhz) / rows;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int IVL = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(IVL + 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(IVL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int MAX_PENDING = 8,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] pend,
  output logic          nonzero
);
  logic full;

  assign full    = (pend == PW'(MAX_PENDING));
  assign nonzero = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (inc && !dec) begin
      if (!full) pend <= pend + 1'b1;
    end else if (dec && !inc) begin
      pend <= pend - 1'b1;
    end
  end
endmodule

// File: rtl/ref_cycle_fsm.sv
module ref_cycle_fsm
  import dram_ref_pkg::*;
#(
  parameter int PWR_CYC     = 50000,
  parameter int T_CSR       = 3,
  parameter int T_RAS       = 13,
  parameter int T_RP        = 8,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic pend_nz,
  output logic ras_n,
  output logic cas_n,
  output logic done,
  output logic init_done,
  output logic busy,
  output logic take,
  output logic pwr_wait
);
  localparam int TW = $clog2(imax(imax(PWR_CYC, T_RAS), imax(T_CSR, T_RP)) + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  ref_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] limit;
  logic [IW-1:0] icnt_q;
  logic          init_q;
  logic          last;
  logic          bump_init;
  logic          init_last;

  always_comb begin
    case (st_q)
      ST_PWR:  limit = TW'(PWR_CYC);
      ST_CSR:  limit = TW'(T_CSR);
      ST_RAS:  limit = TW'(T_RAS);
      ST_PRE:  limit = TW'(T_RP);
      default: limit = TW'(1);
    endcase
  end

  assign last      = (tmr_q == limit - 1'b1);
  assign init_last = (icnt_q == IW'(INIT_CYCLES - 1));

  always_comb begin
    st_d      = st_q;
    take      = 1'b0;
    done      = 1'b0;
    bump_init = 1'b0;
    case (st_q)
      ST_PWR:  if (last) st_d = ST_CSR;
      ST_IDLE: if (pend_nz && grant) begin
                 st_d = ST_CSR;
                 take = 1'b1;
               end
      ST_CSR:  if (last) st_d = ST_RAS;
      ST_RAS:  if (last) st_d = ST_PRE;
      ST_PRE:  if (last) begin
                 done = 1'b1;
                 if (!init_q) begin
                   bump_init = 1'b1;
                   st_d = init_last ? ST_IDLE : ST_CSR;
                 end else if (pend_nz) begin
                   st_d = ST_CSR;
                   take = 1'b1;
                 end else begin
                   st_d = ST_IDLE;
                 end
               end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      tmr_q  <= '0;
      icnt_q <= '0;
      init_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= ((st_d != st_q) || (st_q == ST_IDLE)) ? '0 : tmr_q + 1'b1;
      if (bump_init) begin
        icnt_q <= icnt_q + 1'b1;
        if (init_last) init_q <= 1'b1;
      end
    end
  end

  assign ras_n     = (st_q != ST_RAS);
  assign cas_n     = !((st_q == ST_CSR) || (st_q == ST_RAS));
  assign busy      = (st_q != ST_IDLE);
  assign pwr_wait  = (st_q == ST_PWR);
  assign init_done = init_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ      = 250,
  parameter int SPEED_GRADE  = 0,
  parameter int LOW_POWER    = 0,
  parameter int ROWS         = 2048,
  parameter int POWERUP_US   = 200,
  parameter int RETENTION_US = (LOW_POWER != 0) ? 128000 : 32000,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PENDING  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic refresh_req,
  output logic refresh_done,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int T_CSR   = ns_to_cyc(10, CLK_MHZ);
  localparam int T_CHR   = ns_to_cyc(10, CLK_MHZ);
  localparam int T_RPC   = ns_to_cyc(5, CLK_MHZ);
  localparam int T_RAS   = imax(ns_to_cyc(ras_low_ns(SPEED_GRADE), CLK_MHZ), T_CHR);
  localparam int T_RP    = imax(ns_to_cyc(precharge_ns(SPEED_GRADE), CLK_MHZ), T_RPC);
  localparam int PWR_CYC = POWERUP_US * CLK_MHZ;
  localparam int IVL     = refresh_interval(RETENTION_US, CLK_MHZ, ROWS);
  localparam int PW      = $clog2(MAX_PENDING + 1);

  // named internal events, observed by the bound checker
  logic          tick;
  logic          take;
  logic          pwr_wait;
  logic          busy;
  logic          pend_nz;
  logic [PW-1:0] pend_cnt;

  ref_interval_timer #(.IVL(IVL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .tick (tick)
  );

  ref_pending_ctr #(.MAX_PENDING(MAX_PENDING)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (tick),
    .dec    (take),
    .pend   (pend_cnt),
    .nonzero(pend_nz)
  );

  ref_cycle_fsm #(
    .PWR_CYC    (PWR_CYC),
    .T_CSR      (T_CSR),
    .T_RAS      (T_RAS),
    .T_RP       (T_RP),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .pend_nz  (pend_nz),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .done     (refresh_done),
    .init_done(init_done),
    .busy     (busy),
    .take     (take),
    .pwr_wait (pwr_wait)
  );

  assign refresh_req = init_done && (pend_nz || busy);
  assign we_n        = 1'b1;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int MAX_PENDING = 8,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant,
  input logic          refresh_req,
  input logic          refresh_done,
  input logic          init_done,
  input logic          ras_n,
  input logic          cas_n,
  input logic          pwr_wait,
  input logic          tick,
  input logic          take,
  input logic [PW-1:0] pend
);
  assert_pwr_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_wait |-> (ras_n && cas_n && !refresh_done));

  assert_no_req_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_cas_with_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

  assert_start_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && $past(init_done)) |-> ($past(grant) || $past(refresh_done)));

  assert_pend_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PENDING));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && pend == PW'(MAX_PENDING)) |=> (pend == PW'(MAX_PENDING)));

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && pend < PW'(MAX_PENDING)) |=> (pend == $past(pend) + 1'b1));

  assert_take_has_work_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend != '0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |=> !refresh_done);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.MAX_PENDING(MAX_PENDING)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant       (grant),
  .refresh_req (refresh_req),
  .refresh_done(refresh_done),
  .init_done   (init_done),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .pwr_wait    (pwr_wait),
  .tick        (tick),
  .take        (take),
  .pend        (pend_cnt)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int MHZ   = 250;
  localparam int GRADE = 1;
  localparam int PWRUS = 4;
  localparam int RETUS = 4096;
  localparam int NROWS = 2048;

  // bench's own view of the timing rules
  function automatic int cyc_up(input int ns);
    int whole;
    whole = (ns * MHZ) / 1000;
    if ((ns * MHZ) % 1000 != 0) whole = whole + 1;
    return (whole == 0) ? 1 : whole;
  endfunction

  localparam int B_CSR = cyc_up(10);
  localparam int B_RAS = cyc_up(50 + GRADE * 10);
  localparam int B_RP  = cyc_up(30 + GRADE * 10);
  localparam int B_RPC = cyc_up(5);
  localparam int B_PWR = PWRUS * MHZ;
  localparam int B_IVL = (RETUS / NROWS) * MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic refresh_req, refresh_done, init_done, ras_n, cas_n, we_n;

  dram_refresh_sched #(
    .CLK_MHZ(MHZ), .SPEED_GRADE(GRADE), .LOW_POWER(0), .ROWS(NROWS),
    .POWERUP_US(PWRUS), .RETENTION_US(RETUS), .INIT_CYCLES(8), .MAX_PENDING(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant), .refresh_req(refresh_req),
    .refresh_done(refresh_done), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // cycle counters driven from the clock
  int cyc_rst = 0;
  int ic = 0;
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (!rst_n) begin
      cyc_rst <= 0;
      ic <= 0;
    end else begin
      cyc_rst <= cyc_rst + 1;
      if (init_done) ic <= ic + 1;
    end
  end

  always @(posedge clk) begin
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      report();
    end
  end

  // waveform monitor, sampled away from the active edge
  int  cas_lo_run = 0, cas_hi_run = 1000000, ras_lo_run = 0, ras_hi_run = 1000000;
  int  since_rise = 0;
  int  dones_total = 0, dones_pre_init = 0, req_in_init = 0, cas_falls_post = 0;
  int  first_fall_cyc = -1;
  bit  ras_p = 1'b1, cas_p = 1'b1, done_p = 1'b0, grant_p = 1'b0, init_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_p && !ras_n) begin
        chk(cas_lo_run >= B_CSR, "R4 cas lead", cas_lo_run, B_CSR);
        chk(we_n == 1'b1, "R5 we at ras fall", int'(we_n), 1);
        chk(ras_hi_run >= B_RP, "R6 ras precharge", ras_hi_run, B_RP);
      end
      if (!ras_p && ras_n) begin
        chk(ras_lo_run >= B_RAS, "R6 ras width", ras_lo_run, B_RAS);
        chk(cas_n && cas_lo_run >= ras_lo_run + B_CSR, "R4 cas hold", cas_lo_run, ras_lo_run + B_CSR);
        since_rise = 0;
      end else begin
        since_rise++;
      end
      if (cas_p && !cas_n) begin
        chk(cas_hi_run >= B_RPC, "R7 cas high", cas_hi_run, B_RPC);
        if (first_fall_cyc < 0) begin
          first_fall_cyc = cyc_rst;
          chk(cyc_rst == B_PWR, "R1 powerup wait", cyc_rst, B_PWR);
        end
        if (init_p) begin
          cas_falls_post++;
          chk(grant_p || done_p, "R8 start condition", int'(grant_p), 1);
        end
      end
      if (refresh_done) begin
        dones_total++;
        if (!init_done) dones_pre_init++;
        chk(!done_p, "R10 done width", int'(done_p), 0);
        chk(since_rise == B_RP - 1, "R10 done timing", since_rise, B_RP - 1);
      end
      if (!init_done && refresh_req) req_in_init++;
      if (init_done && !init_p)
        chk(done_p, "R2 init_done after last done", int'(done_p), 1);

      if (cas_n) begin cas_hi_run++; cas_lo_run = 0; end
      else       begin cas_lo_run++; cas_hi_run = 0; end
      if (ras_n) begin ras_hi_run++; ras_lo_run = 0; end
      else       begin ras_lo_run++; ras_hi_run = 0; end
      ras_p   = ras_n;
      cas_p   = cas_n;
      done_p  = refresh_done;
      grant_p = grant;
      init_p  = init_done;
    end
  end

  task automatic burst_count(output int n, output bit last_done_before_drop);
    n = 0;
    last_done_before_drop = 1'b0;
    do begin
      @(negedge clk);
      if (refresh_done) n++;
      last_done_before_drop = done_p;
    end while (refresh_req);
  endtask

  initial begin
    int  base_t, base_d, n, falls0;
    bit  ld;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 reset strobes", int'(ras_n & cas_n & we_n), 1);
    chk(!refresh_req && !refresh_done, "R2 reset req/done", int'(refresh_req | refresh_done), 0);
    chk(!init_done, "R2 reset init_done", int'(init_done), 0);
    rst_n = 1'b1;

    while (!init_done) @(negedge clk);
    chk(first_fall_cyc == B_PWR, "R1 first cas fall", first_fall_cyc, B_PWR);
    chk(dones_pre_init == 8, "R2 init burst length", dones_pre_init, 8);
    chk(req_in_init == 0, "R2 req during init", req_in_init, 0);

    // R3: first obligation one interval after init_done, grant held low
    while (ic != B_IVL - 1) @(negedge clk);
    chk(!refresh_req, "R3 req before interval", int'(refresh_req), 0);
    @(negedge clk);
    chk(refresh_req, "R3 req at interval", int'(refresh_req), 1);

    // R9: let obligations saturate, then grant
    falls0 = cas_falls_post;
    while (ic != 10 * B_IVL) @(negedge clk);
    chk(cas_falls_post == falls0 && ras_n && cas_n, "R8 idle without grant", cas_falls_post - falls0, 0);
    grant = 1'b1;
    burst_count(n, ld);
    chk(n == 8, "R9 saturated burst", n, 8);
    chk(ld, "R10 req drops after final done", int'(ld), 1);
    grant = 1'b0;
    base_t = ic / B_IVL;
    base_d = dones_total;

    // R9 corner: grant lands on the same edge as a new obligation
    while (ic != (base_t + 3) * B_IVL - 1) @(negedge clk);
    grant = 1'b1;
    burst_count(n, ld);
    chk(n == 3, "R9 take and tick same edge", n, 3);
    grant = 1'b0;

    // random grant pattern, no saturation possible
    for (int it = 0; it < 30; it++) begin
      int lo, hi;
      lo = 1 + int'($urandom % (2 * B_IVL));
      hi = 1 + int'($urandom % 300);
      grant = 1'b0;
      repeat (lo) @(negedge clk);
      grant = 1'b1;
      repeat (hi) @(negedge clk);
    end
    grant = 1'b1;
    do @(negedge clk); while (refresh_req);
    chk(dones_total - base_d == ic / B_IVL - base_t, "R11 obligations served",
        dones_total - base_d, ic / B_IVL - base_t);
    grant = 1'b0;
    repeat (20) @(negedge clk);
    report();
  end
endmodule